// File: doc/BRIEF.md
# Unsigned Add, Subtract and Multiply Unit

This execution unit performs the three unsigned integer operations of a 64-bit register machine that never trap: wrap-around addition, wrap-around subtraction, and full-width multiplication. The first operand is a 64-bit value. The second operand comes either from a 64-bit register value or from an 8-bit immediate, and a select flag picks between them. The immediate is zero-extended before use.

Add and subtract finish one cycle after the start request is accepted. Multiply is a sequential operation. A shift-and-add engine retires a fixed slice of multiplier bits on each clock into a 128-bit accumulator. When the product is complete, its low half appears on the result output and its high half is latched into a separate high-product register. A start/busy/done handshake frames each operation. No operation raises an exception or an overflow indication.

Top module: `uarith_unit`

## Requirements
- R1: When start is accepted with op code 2'b00 (add), result_o equals (Y + Z) mod 2^64 and done_o is high in the next cycle. There is no overflow indication.
- R2: When start is accepted with op code 2'b01 (subtract), result_o equals (Y - Z) mod 2^64 and done_o is high in the next cycle.
- R3: When use_imm_i is 1, Z is the 8-bit immediate zero-extended to 64 bits and z_reg_i has no effect. When use_imm_i is 0, Z is z_reg_i.
- R4: With op code 2'b10 (multiply), the 128-bit unsigned product Y*Z is split on completion: bits 63:0 go to result_o and bits 127:64 go to hi_o.
- R5: For a multiply, done_o rises 10 cycles after the rising edge that accepts start. busy_o is high for the 9 cycles before that, and done_o stays low while busy_o is high.
- R6: While busy_o is high, a start request is ignored. It causes no extra done_o pulse and does not change the multiply in progress.
- R7: hi_o changes only when a multiply completes. Add, subtract and idle cycles leave it unchanged.
- R8: done_o is high only in the cycle after an accepted add or subtract, or in the completion cycle of a multiply. It is a single-cycle pulse for each operation.
- R9: A start request with op code 2'b11 (reserved) is ignored: no done_o pulse follows, and result_o and hi_o keep their values.
- R10: After reset, result_o and hi_o are zero, and busy_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation; accepted when busy_o is low |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 multiply, 11 reserved |
| y_i | input | 64 | First operand |
| z_reg_i | input | 64 | Second operand, register form |
| z_imm_i | input | 8 | Second operand, immediate form |
| use_imm_i | input | 1 | 1 selects the zero-extended immediate as Z |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| result_o | output | 64 | Sum, difference or low product half |
| hi_o | output | 64 | High half of the last completed product |

## Verification
The operand checks assume that y_i, z_reg_i, z_imm_i, use_imm_i and op_i are stable only in the cycle where start_i is sampled. The add and subtract properties therefore compare the next result against values taken with $past at the accepting edge. The latency and hand-off properties assume that reset is applied before the first request, and they count busy cycles with a counter of their own rather than a fixed delay. The stimulus drives every input on the falling edge and never raises start_i during reset. It raises start_i during a running multiply only in the dedicated test for ignored requests, where the operands are deliberately different so that an accidental acceptance would be visible.

// File: rtl/uarith_pkg.sv
package uarith_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_RSV = 2'b11
    } uarith_op_e;

endpackage

// File: rtl/uarith_zsel.sv
module uarith_zsel #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic [DATA_W-1:0] z_reg_i,
    input  logic [IMM_W-1:0]  z_imm_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] z_o
);
    // Zero-extend the immediate byte to full width.
    logic [DATA_W-1:0] imm_ext;

    assign imm_ext = DATA_W'(z_imm_i);
    assign z_o     = use_imm_i ? imm_ext : z_reg_i;

endmodule

// File: rtl/uarith_addsub.sv
module uarith_addsub #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o
);
    // Subtraction as a + ~b + 1; the carry out is discarded (mod 2^DATA_W).
    logic [DATA_W-1:0] b_eff;

    assign b_eff = b_i ^ {DATA_W{sub_i}};
    assign sum_o = a_i + b_eff + DATA_W'(sub_i);

endmodule

// File: rtl/uarith_mul_step.sv
module uarith_mul_step #(
    parameter int PROD_W = 128,
    parameter int BPS    = 7
) (
    input  logic [PROD_W-1:0] acc_i,
    input  logic [PROD_W-1:0] mcand_i,
    input  logic [BPS-1:0]    digit_i,
    output logic [PROD_W-1:0] acc_o
);
    // One shifted copy of the multiplicand per multiplier bit in this slice.
    logic [PROD_W-1:0] terms [BPS];

    for (genvar b = 0; b < BPS; b++) begin : g_term
        assign terms[b] = digit_i[b] ? (mcand_i << b) : '0;
    end

    always_comb begin
        acc_o = acc_i;
        for (int b = 0; b < BPS; b++) begin
            acc_o = acc_o + terms[b];
        end
    end

endmodule

// File: rtl/uarith_unit.sv
module uarith_unit
    import uarith_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int IMM_W      = 8,
    parameter int MUL_CYCLES = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic [DATA_W-1:0] z_reg_i,
    input  logic [IMM_W-1:0]  z_imm_i,
    input  logic              use_imm_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o,
    output logic [DATA_W-1:0] hi_o
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int BPS    = (DATA_W + MUL_CYCLES - 1) / MUL_CYCLES;
    localparam int MPL_W  = BPS * MUL_CYCLES;
    localparam int CNT_W  = $clog2(MUL_CYCLES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [PROD_W-1:0] acc;
        logic [PROD_W-1:0] mcand;
        logic [MPL_W-1:0]  mplier;
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] hi;
    } uarith_state_t;

    uarith_state_t st_d, st_q;

    // Operand path.
    logic [DATA_W-1:0] z_sel;
    logic [DATA_W-1:0] addsub_sum;
    uarith_op_e        op;

    assign op = uarith_op_e'(op_i);

    uarith_zsel #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W)
    ) u_zsel (
        .z_reg_i   (z_reg_i),
        .z_imm_i   (z_imm_i),
        .use_imm_i (use_imm_i),
        .z_o       (z_sel)
    );

    uarith_addsub #(
        .DATA_W (DATA_W)
    ) u_addsub (
        .a_i   (y_i),
        .b_i   (z_sel),
        .sub_i (op == OP_SUB),
        .sum_o (addsub_sum)
    );

    // Multiply step inputs: fresh operands on the starting edge, state afterwards.
    logic [PROD_W-1:0] step_acc;
    logic [PROD_W-1:0] step_mcand;
    logic [MPL_W-1:0]  step_mplier;
    logic [PROD_W-1:0] step_sum;

    always_comb begin
        if (st_q.busy) begin
            step_acc    = st_q.acc;
            step_mcand  = st_q.mcand;
            step_mplier = st_q.mplier;
        end else begin
            step_acc    = '0;
            step_mcand  = PROD_W'(y_i);
            step_mplier = MPL_W'(z_sel);
        end
    end

    uarith_mul_step #(
        .PROD_W (PROD_W),
        .BPS    (BPS)
    ) u_mul_step (
        .acc_i   (step_acc),
        .mcand_i (step_mcand),
        .digit_i (step_mplier[BPS-1:0]),
        .acc_o   (step_sum)
    );

    // Next-state logic.
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        if (st_q.busy) begin
            st_d.acc    = step_sum;
            st_d.mcand  = step_mcand << BPS;
            st_d.mplier = step_mplier >> BPS;
            st_d.cnt    = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(MUL_CYCLES - 1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.cnt    = '0;
                st_d.result = step_sum[DATA_W-1:0];
                st_d.hi     = step_sum[PROD_W-1:DATA_W];
            end
        end else if (start_i) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    st_d.result = addsub_sum;
                    st_d.done   = 1'b1;
                end
                OP_MUL: begin
                    st_d.busy   = 1'b1;
                    st_d.cnt    = CNT_W'(1);
                    st_d.acc    = step_sum;
                    st_d.mcand  = step_mcand << BPS;
                    st_d.mplier = step_mplier >> BPS;
                end
                default: begin
                    // Reserved code: request dropped.
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign result_o = st_q.result;
    assign hi_o     = st_q.hi;

endmodule

// File: rtl/uarith_unit_chk.sv
module uarith_unit_chk #(
    parameter int DATA_W     = 64,
    parameter int IMM_W      = 8,
    parameter int MUL_CYCLES = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] y_i,
    input logic [DATA_W-1:0] z_reg_i,
    input logic [IMM_W-1:0]  z_imm_i,
    input logic              use_imm_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic [DATA_W-1:0] hi_o
);
    localparam int RUN_W = $clog2(MUL_CYCLES) + 1;

    logic [DATA_W-1:0] zx;
    logic [RUN_W-1:0]  run_q;

    assign zx = use_imm_i ? {{(DATA_W-IMM_W){1'b0}}, z_imm_i} : z_reg_i;

    // Length of the current busy stretch, counted independently of the design.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy_o) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    a_r1_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i == 2'b00 |=> done_o && result_o == $past(y_i + zx));

    a_r2_sub_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i == 2'b01 |=> done_o && result_o == $past(y_i - zx));

    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q == '0 || run_q == RUN_W'(MUL_CYCLES - 1)));

    a_r5_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o && run_q < RUN_W'(MUL_CYCLES - 1));

    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> busy_o || done_o);

    a_r7_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(hi_o));

    a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o) || $past(start_i && !op_i[1]));

    a_r9_reserved_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i == 2'b11 |=> !done_o && $stable(result_o) && $stable(hi_o));

endmodule

bind uarith_unit uarith_unit_chk #(
    .DATA_W     (DATA_W),
    .IMM_W      (IMM_W),
    .MUL_CYCLES (MUL_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .y_i       (y_i),
    .z_reg_i   (z_reg_i),
    .z_imm_i   (z_imm_i),
    .use_imm_i (use_imm_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .hi_o      (hi_o)
);

// File: tb/uarith_unit_bench.sv
`timescale 1ns/1ps
module uarith_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [63:0] y_i = '0;
    logic [63:0] z_reg_i = '0;
    logic [7:0]  z_imm_i = '0;
    logic        use_imm_i = 1'b0;
    logic        busy_o, done_o;
    logic [63:0] result_o, hi_o;

    always #2 clk = ~clk;

    uarith_unit u_uarith_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .op_i      (op_i),
        .y_i       (y_i),
        .z_reg_i   (z_reg_i),
        .z_imm_i   (z_imm_i),
        .use_imm_i (use_imm_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o),
        .hi_o      (hi_o)
    );

    typedef struct {
        logic [63:0] res;
        logic [63:0] hi;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          checks = 0;
    int          errors = 0;
    int          done_cnt = 0;
    logic [63:0] model_hi = '0;
    bit          finished = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per done pulse.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            done_cnt++;
            if (sbq.size() == 0) begin
                check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(result_o == e.res, {e.tag, " result"}, result_o, e.res);
                check(hi_o == e.hi, {e.tag, " hi (R7)"}, hi_o, e.hi);
            end
        end
    end

    // Driver: waits for idle, raises start for one edge, pushes the expectation.
    task automatic issue(input logic [1:0] op, input logic [63:0] y, input logic [63:0] z,
                         input logic [7:0] imm, input logic ui, input string tag);
        logic [63:0]  zx;
        logic [127:0] prod;
        exp_t         e;
        while (busy_o) @(negedge clk);
        zx = ui ? {56'd0, imm} : z;
        e.tag = tag;
        e.hi  = model_hi;
        case (op)
            2'b00: e.res = y + zx;
            2'b01: e.res = y - zx;
            2'b10: begin
                prod     = {64'd0, y} * {64'd0, zx};
                e.res    = prod[63:0];
                e.hi     = prod[127:64];
                model_hi = prod[127:64];
            end
            default: e.res = '0;
        endcase
        if (op != 2'b11) sbq.push_back(e);
        op_i = op; y_i = y; z_reg_i = z; z_imm_i = imm; use_imm_i = ui; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        z_reg_i = 64'hDEAD_BEEF_0BAD_F00D;
        z_imm_i = 8'h5A;
    endtask

    task automatic measure(input logic [1:0] op, input logic [63:0] y, input logic [63:0] z,
                           input int exp_lat, input string tag);
        int lat;
        issue(op, y, z, 8'h00, 1'b0, tag);
        lat = 1;
        while (!done_o && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, {tag, " latency"}, 64'(lat), 64'(exp_lat));
    endtask

    task automatic drain();
        int n = 0;
        while ((busy_o || sbq.size() != 0) && n < 100) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] lfsr;
        int          d0;
        logic [63:0] r0;
        repeat (4) @(negedge clk);
        // R10: reset state
        check(result_o == 0, "R10 result", result_o, 0);
        check(hi_o == 0, "R10 hi", hi_o, 0);
        check({busy_o, done_o} == 2'b00, "R10 busy/done", {62'd0, busy_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: add, with and without wrap
        issue(2'b00, 64'd10, 64'd20, 8'h00, 1'b0, "R1 add");
        issue(2'b00, '1, 64'd1, 8'h00, 1'b0, "R1 add wrap");
        // R2: subtract, with borrow wrap
        issue(2'b01, 64'd5, 64'd3, 8'h00, 1'b0, "R2 sub");
        issue(2'b01, 64'd0, 64'd1, 8'h00, 1'b0, "R2 sub wrap");
        // R3: immediate, register Z differs
        issue(2'b00, 64'd100, 64'hFFFF_0000_FFFF_0000, 8'hFF, 1'b1, "R3 add imm");
        issue(2'b01, 64'd3, 64'd1, 8'h80, 1'b1, "R3 sub imm");
        drain();

        // R4: multiply
        issue(2'b10, 64'd3, 64'd5, 8'h00, 1'b0, "R4 mul small");
        issue(2'b10, '1, '1, 8'h00, 1'b0, "R4 mul max");
        issue(2'b10, 64'h1234_5678_9ABC_DEF0, 64'd0, 8'hC8, 1'b1, "R3 R4 mul imm");
        // R7: add after mul keeps hi
        issue(2'b00, 64'd7, 64'd8, 8'h00, 1'b0, "R7 add after mul");
        drain();
        check(hi_o == model_hi, "R7 hi after add", hi_o, model_hi);

        // R5 latency, R1 latency
        measure(2'b10, 64'hFEDC_BA98_7654_3210, 64'h0F0F_0F0F_F0F0_F0F0, 10, "R5 mul");
        measure(2'b00, 64'd1, 64'd2, 1, "R1 add");
        drain();

        // R6: start during busy ignored
        d0 = done_cnt;
        issue(2'b10, 64'd1000, 64'd1000, 8'h00, 1'b0, "R6 mul under requests");
        op_i = 2'b00; y_i = 64'd77; z_reg_i = 64'd1; use_imm_i = 1'b0; start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        drain();
        check(done_cnt == d0 + 1, "R6 done count", 64'(done_cnt - d0), 64'd1);
        check(result_o == 64'd1000000, "R6 result", result_o, 64'd1000000);

        // R9: reserved op dropped
        d0 = done_cnt;
        r0 = result_o;
        issue(2'b11, 64'd9, 64'd9, 8'h00, 1'b0, "R9 reserved");
        repeat (4) @(negedge clk);
        check(done_cnt == d0, "R9 no done", 64'(done_cnt - d0), 64'd0);
        check(result_o == r0, "R9 result kept", result_o, r0);
        check(hi_o == model_hi, "R9 hi kept", hi_o, model_hi);

        // Mixed patterns
        lfsr = 64'hACE1_2468_1357_9BDF;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            issue(2'(i % 3), lfsr, {lfsr[31:0], lfsr[63:32]}, lfsr[7:0], lfsr[5],
                  (i % 3 == 0) ? "R1 mix" : (i % 3 == 1) ? "R2 mix" : "R4 mix");
        end
        drain();
        check(sbq.size() == 0, "R8 queue empty", 64'(sbq.size()), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule